// File: doc/BRIEF.md
# Pin Bank with Per-Pin Interrupt Triggers

This block is a bank of up to 32 general-purpose pins behind a 32-bit word-indexed register port. Each pin can be an input or an output. Outputs are driven from a stored value word. Reads of that same word return the pin levels after a two-flop synchronizer. The pad buffers stay outside: the block hands out a drive vector and an output-enable vector, and it takes in the sampled pad levels.

Every pin has an interrupt trigger set by three configuration bits held in three separate words: a mode bit (level or edge), a sense bit (high/rising or low/falling) and a dual-edge bit. A trigger event sets a sticky status bit. Software clears a status bit by writing a one to it. An enable mask gates status into a pending word, and any pending bit raises the single interrupt line. A read-only version word tells software that dual-edge triggering is present.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the interrupt-enable word (index 2) reads 0, the direction word (index 1) reads all ones, `pin_oe` is 0 and `irq` is low.
- R2: Word indices are the byte offsets divided by four: 0 value, 1 direction, 2 enable, 3 status, 4 pending, 5 clear, 6 mode, 7 sense, 8 version, 9 dual-edge. The version word reads the VERSION parameter, at least 3. The clear word reads 0.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). `pin_out` always carries the value word written at index 0.
- R4: A read of index 0 returns `pin_in` through a two-flop synchronizer. A change made before a clock edge shows in the read after the second rising edge and not after the first.
- R5: With its mode bit at 0 a pin is level-triggered. The status bit sets on every cycle in which the synchronized level equals the sense bit (1 = high, 0 = low).
- R6: With its mode bit at 1 and its dual-edge bit at 0, a synchronized rising edge (sense 1) or falling edge (sense 0) sets the status bit. The other edge does not.
- R7: With both the mode bit and the dual-edge bit at 1, either edge sets the status bit, whatever the sense bit holds.
- R8: Writing index 5 clears every status bit whose write-data bit is 1. Bits written 0 keep their value, and status bits never drop without such a write.
- R9: A trigger event and a clear of the same bit in the same cycle leave the bit set. A pin held at its active level therefore reads as set right after a clear.
- R10: Pending (index 4) equals status ANDed with enable, and `irq` is the OR of all pending bits. Status latches even when the pin's enable bit is 0.
- R11: An edge made on `pin_in` before a clock edge sets status on the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index, 0 when no read is selected |
| pin_in | input | NPINS | Levels sampled at the pads |
| pin_out | output | NPINS | Output levels from the value word |
| pin_oe | output | NPINS | Output enable, 1 where the pin is an output |
| irq | output | 1 | Combined interrupt, high while any pending bit is set |

## Verification
A corrupted synchronizer or previous-sample register shows up as a wrong value-word read within two cycles. It also shows up as a status bit that sets on the wrong edge, or that fails to set, in the third cycle after the pin moves. A wrong trigger decode for one of the eight mode/sense/dual-edge combinations shows in the status word and the pending word on the first transition in that mode. A status register that drops or keeps bits wrongly shows at the next status read and, where the pin is enabled, on `irq` in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned IDX_W = 4;

  // word index = byte offset / 4; software decodes these positions
  typedef enum logic [IDX_W-1:0] {
    RI_LEVEL = 4'd0,
    RI_DIR   = 4'd1,
    RI_IEN   = 4'd2,
    RI_STAT  = 4'd3,
    RI_PEND  = 4'd4,
    RI_CLR   = 4'd5,
    RI_MODE  = 4'd6,
    RI_SENSE = 4'd7,
    RI_VER   = 4'd8,
    RI_DUAL  = 4'd9
  } gpio_reg_e;

  localparam int unsigned MIN_DUAL_VERSION = 3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] smp,
  output logic [NPINS-1:0] prev
);

  // STAGES synchronizer flops plus one more flop holding the previous sample
  localparam int unsigned DEPTH = STAGES + 1;

  logic [NPINS-1:0] chain_q [DEPTH];
  logic [NPINS-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = pin_in;
    for (int i = 1; i < DEPTH; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chain_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) chain_q[i] <= chain_d[i];
    end
  end

  assign smp  = chain_q[STAGES-1];
  assign prev = chain_q[STAGES];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int unsigned NPINS    = 32,
  parameter bit          HAS_DUAL = 1'b1
) (
  input  logic [NPINS-1:0] smp,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] mode_edge,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] dual,
  output logic [NPINS-1:0] trig_ev
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise_w, fall_w, lvl_w, edg_w;

    assign rise_w = smp[g] & ~prev[g];
    assign fall_w = ~smp[g] & prev[g];
    assign lvl_w  = sense[g] ? smp[g] : ~smp[g];

    if (HAS_DUAL) begin : g_dual
      assign edg_w = dual[g] ? (rise_w | fall_w)
                             : (sense[g] ? rise_w : fall_w);
    end else begin : g_single
      logic unused_dual;
      assign unused_dual = dual[g];
      assign edg_w = sense[g] ? rise_w : fall_w;
    end

    assign trig_ev[g] = mode_edge[g] ? edg_w : lvl_w;
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] trig_ev,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] status,
  output logic [NPINS-1:0] pending,
  output logic             irq
);

  logic [NPINS-1:0] stat_q, stat_d;
  logic [NPINS-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  // set beats clear in the same cycle
  always_comb begin
    stat_d = (stat_q & ~clr_eff) | trig_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status  = stat_q;
  assign pending = stat_q & ien;
  assign irq     = |pending;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned VERSION = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam bit HAS_DUAL = (VERSION >= MIN_DUAL_VERSION);

  // register write strobes
  logic wr_any;
  logic we_level, we_dir, we_ien, we_clr, we_mode, we_sense, we_dual;
  logic [NPINS-1:0] wd;

  assign wr_any   = bus_sel & bus_wr;
  assign we_level = wr_any & (bus_addr == RI_LEVEL);
  assign we_dir   = wr_any & (bus_addr == RI_DIR);
  assign we_ien   = wr_any & (bus_addr == RI_IEN);
  assign we_clr   = wr_any & (bus_addr == RI_CLR);
  assign we_mode  = wr_any & (bus_addr == RI_MODE);
  assign we_sense = wr_any & (bus_addr == RI_SENSE);
  assign we_dual  = wr_any & (bus_addr == RI_DUAL);
  assign wd       = bus_wdata[NPINS-1:0];

  // configuration registers
  logic [NPINS-1:0] level_q, dir_q, ien_q, mode_q, sense_q, dual_q;
  logic [NPINS-1:0] level_d, dir_d, ien_d, mode_d, sense_d, dual_d;

  always_comb begin
    level_d = we_level ? wd : level_q;
    dir_d   = we_dir   ? wd : dir_q;
    ien_d   = we_ien   ? wd : ien_q;
    mode_d  = we_mode  ? wd : mode_q;
    sense_d = we_sense ? wd : sense_q;
    dual_d  = (we_dual && HAS_DUAL) ? wd : dual_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '1;
      ien_q   <= '0;
      mode_q  <= '0;
      sense_q <= '0;
      dual_q  <= '0;
    end else begin
      level_q <= level_d;
      dir_q   <= dir_d;
      ien_q   <= ien_d;
      mode_q  <= mode_d;
      sense_q <= sense_d;
      dual_q  <= dual_d;
    end
  end

  assign pin_out = level_q;
  assign pin_oe  = ~dir_q;

  // input path
  logic [NPINS-1:0] smp_w, prev_w, trig_w;

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .smp   (smp_w),
    .prev  (prev_w)
  );

  gpio_trig_detect #(.NPINS(NPINS), .HAS_DUAL(HAS_DUAL)) u_trig (
    .smp      (smp_w),
    .prev     (prev_w),
    .mode_edge(mode_q),
    .sense    (sense_q),
    .dual     (dual_q),
    .trig_ev  (trig_w)
  );

  logic [NPINS-1:0] stat_w, pend_w;

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_ev (trig_w),
    .clr_we  (we_clr),
    .clr_mask(wd),
    .ien     (ien_q),
    .status  (stat_w),
    .pending (pend_w),
    .irq     (irq)
  );

  // read mux
  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  logic rd_act;
  assign rd_act = bus_sel & ~bus_wr;

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      case (bus_addr)
        RI_LEVEL: bus_rdata = widen(smp_w);
        RI_DIR:   bus_rdata = widen(dir_q);
        RI_IEN:   bus_rdata = widen(ien_q);
        RI_STAT:  bus_rdata = widen(stat_w);
        RI_PEND:  bus_rdata = widen(pend_w);
        RI_MODE:  bus_rdata = widen(mode_q);
        RI_SENSE: bus_rdata = widen(sense_q);
        RI_VER:   bus_rdata = BUS_W'(VERSION);
        RI_DUAL:  bus_rdata = widen(dual_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq,
  input logic [NPINS-1:0]  stat,
  input logic [NPINS-1:0]  trig,
  input logic [NPINS-1:0]  ien,
  input logic [NPINS-1:0]  mode,
  input logic [NPINS-1:0]  smp,
  input logic [NPINS-1:0]  prev
);

  logic clr_wr;
  assign clr_wr = bus_sel & bus_wr & (bus_addr == RI_CLR);

  // R8: a cleared bit with no coincident event is 0 afterwards
  a_r8_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((stat & $past(bus_wdata[NPINS-1:0]) & ~$past(trig)) == '0));

  // R8: without a clear write, no status bit drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

  // R9: every trigger event is latched, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((stat & $past(trig)) == $past(trig)));

  // R6 / R7: edge-mode events only where the synchronized sample moved
  a_r6_edge_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (trig & mode & ~(smp ^ prev)) == '0);

  // R10: irq needs at least one enabled bit
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0));

  // R2: version word reports dual-edge support
  a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == RI_VER) |-> (bus_rdata >= BUS_W'(MIN_DUAL_VERSION)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .stat     (stat_w),
  .trig     (trig_w),
  .ien      (ien_q),
  .mode     (mode_q),
  .smp      (smp_w),
  .prev     (prev_w)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

  localparam int unsigned N      = 8;
  localparam time         CLK_PER = 10ns;

  localparam logic [3:0] A_LEVEL = 4'd0, A_DIR = 4'd1, A_IEN = 4'd2,
                         A_STAT = 4'd3, A_PEND = 4'd4, A_CLR = 4'd5,
                         A_MODE = 4'd6, A_SENSE = 4'd7, A_VER = 4'd8,
                         A_DUAL = 4'd9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wen;
  logic [3:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [N-1:0]  pins;
  logic [N-1:0]  pout, poe;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  gpio_irq_bank #(.NPINS(N), .VERSION(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wen), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout),
    .pin_oe(poe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wen = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N-1:0] expect_stat(
      input bit md, input bit sn, input bit du,
      input logic [N-1:0] o, input logic [N-1:0] nw);
    logic [N-1:0] act_o, act_n;
    act_o = sn ? o : ~o;
    act_n = sn ? nw : ~nw;
    if (!md) return act_o | act_n;
    if (du)  return o ^ nw;
    return sn ? (nw & ~o) : (o & ~nw);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] o, nw, en, ex;
    rst_n = 1'b0; sel = 1'b0; wen = 1'b0; addr = '0; wdata = '0; pins = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_IEN, d);  chk("R1 enable", d, 32'h0);
    rd(A_DIR, d);  chk("R1 direction", d, 32'hFF);
    chk("R1 pin_oe", {24'h0, poe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 map constants
    rd(A_VER, d);  chk("R2 version", d, 32'd3);
    rd(A_CLR, d);  chk("R2 clear reads zero", d, 32'h0);

    // R3 direction and drive
    wr(A_LEVEL, 32'h5A);
    wr(A_DIR, 32'hF0);
    #1;
    chk("R3 pin_oe", {24'h0, poe}, 32'h0F);
    chk("R3 pin_out", {24'h0, pout}, 32'h5A);
    wr(A_DIR, 32'hFF);
    #1;
    chk("R3 pin_oe back to input", {24'h0, poe}, 32'h00);

    // R4 two-flop read latency
    @(negedge clk); pins = 8'h3C;
    @(negedge clk); addr = A_LEVEL; sel = 1'b1; #1 d = rdata; sel = 1'b0;
    chk("R4 level after one edge", d, 32'h00);
    @(negedge clk); addr = A_LEVEL; sel = 1'b1; #1 d = rdata; sel = 1'b0;
    chk("R4 level after two edges", d, 32'h3C);

    // R11 status latency: rising edge mode, pin 1 rises
    wr(A_MODE, 32'hFF); wr(A_SENSE, 32'hFF); wr(A_DUAL, 32'h00);
    @(negedge clk); pins = 8'h00;
    idle(4);
    wr(A_CLR, 32'hFF);
    @(negedge clk); pins = 8'h02;
    @(negedge clk);
    @(negedge clk); addr = A_STAT; sel = 1'b1; #1 d = rdata; sel = 1'b0;
    chk("R11 not set after two edges", d, 32'h00);
    @(negedge clk); addr = A_STAT; sel = 1'b1; #1 d = rdata; sel = 1'b0;
    chk("R11 set after third edge", d, 32'h02);

    // R8 zero bits keep status
    wr(A_CLR, 32'hFD);
    rd(A_STAT, d); chk("R8 zero write keeps bit", d, 32'h02);
    wr(A_CLR, 32'h02);
    rd(A_STAT, d); chk("R8 one write clears bit", d, 32'h00);

    // R9 set beats clear: level-high, pin 1 held high
    wr(A_MODE, 32'h00);
    idle(3);
    @(negedge clk); sel = 1'b1; wen = 1'b1; addr = A_CLR; wdata = 32'hFF;
    @(negedge clk); sel = 1'b0; wen = 1'b0;
    addr = A_STAT; sel = 1'b1; #1 d = rdata; sel = 1'b0;
    chk("R9 active level survives clear", d, 32'h02);

    // R5 R6 R7 R10 sweep over all trigger settings, pins and directions
    for (int m = 0; m < 8; m++) begin
      bit md, sn, du;
      md = m[2]; sn = m[1]; du = m[0];
      wr(A_MODE,  {32{md}});
      wr(A_SENSE, {32{sn}});
      wr(A_DUAL,  {32{du}});
      for (int p = 0; p < N; p++) begin
        for (int up = 0; up < 2; up++) begin
          string tag;
          o  = up ? 8'h00 : 8'hFF;
          nw = o ^ (8'h01 << p);
          en = p[0] ? 8'h0F : 8'hF0;
          tag = !md ? "R5 level" : (du ? "R7 dual edge" : "R6 single edge");
          wr(A_IEN, {24'h0, en});
          @(negedge clk); pins = o;
          idle(4);
          wr(A_CLR, 32'hFF);
          rd(A_STAT, d);
          ex = !md ? (sn ? o : ~o) : 8'h00;
          chk({tag, " after clear (R9)"}, d, {24'h0, ex});
          @(negedge clk); pins = nw;
          idle(4);
          ex = expect_stat(md, sn, du, o, nw);
          rd(A_STAT, d);
          chk(tag, d, {24'h0, ex});
          rd(A_PEND, d);
          chk("R10 pending", d, {24'h0, ex & en});
          chk("R10 irq", {31'h0, irq}, {31'h0, |(ex & en)});
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule